// File: doc/BRIEF.md
# ULPI PHY-Side Register Responder

This block is the transceiver-side state machine that answers register commands sent by a ULPI link controller over the shared 8-bit data bus. It watches the bus for a command byte whose top two bits mark a register write or a register read. It accepts the byte with a one-cycle NXT pulse. For a read it then takes the bus with DIR and returns a byte from its internal register array. For a write it collects the data byte and commits it when the link signals the end of the access with STP.

One command address, 2Fh, opens the extended register space. The byte that follows the command is then the extended address, and it gets its own NXT acknowledgement. The array holds 64 immediate bytes and 256 extended bytes, each with a fixed reset value.

An external receive-event input stands for incoming USB traffic and outranks every register access. While it is high the block holds DIR high. Any access in flight is abandoned with no change to the registers, and the link is expected to retry the whole command.

Top module: `ulpi_reg_responder`

## Requirements
- R1: After reset, DIR, NXT and the output enable are low. Immediate register i holds A0h XOR i, and extended register i holds FFh XOR i.
- R2: In idle, a bus byte with bits [7:6] = 10b (write) or 11b (read) is accepted. NXT is then high for exactly the one cycle after the sampling edge. Bits [5:0] are the address. A byte with any other top bits produces no NXT.
- R3: For a read, DIR is high in the cycle after the NXT cycle, with the output enable low (turnaround). In the next cycle the output enable is high and the bus carries the register byte. In the cycle after that, DIR and the output enable are both low.
- R4: NXT is never high while DIR is high.
- R5: Command address 2Fh selects the extended set. The byte the link presents in the first cycle after the NXT pulse is taken as the 8-bit extended address, and a second NXT pulse follows in the next cycle.
- R6: For a write, the data byte the link presents in the first cycle after the last NXT pulse is acknowledged with a further NXT pulse in the following cycle.
- R7: A write to an immediate register is committed only on the clock edge where STP is sampled high in the wait-for-stop phase. A later read returns the new byte.
- R8: While a write waits for STP, command bytes on the bus are ignored and produce no NXT.
- R9: A receive event sampled high raises DIR in the next cycle, with NXT and the output enable low. DIR stays high while the event lasts and drops one cycle after the event is sampled low. Any aborted access leaves every register unchanged, even when STP coincides with the event.
- R10: An extended write (command address 2Fh, extended address, data, STP) updates the addressed extended register and leaves the immediate register set alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ulpi_data_in | input | 8 | Bus byte driven by the link |
| ulpi_data_out | output | 8 | Bus byte driven by this block (zero when not enabled) |
| ulpi_data_oe | output | 1 | High when this block drives the bus |
| ulpi_dir | output | 1 | Bus direction; high while this block owns the bus |
| ulpi_nxt | output | 1 | One-cycle acceptance of the byte on the bus |
| ulpi_stp | input | 1 | Link end-of-access strobe |
| rx_event | input | 1 | Receive event; pre-empts any register access |

## Verification
The hardest case to reach from the ports is a receive event that lands in exactly the cycle where a write would commit. STP and the event are both high at the same edge, and the pending byte must be thrown away. The bench steps a write to its wait-for-stop phase, then raises STP and the receive event in the same cycle and reads the register back afterwards. Two other aborts are placed the same way, by cycle-exact tasks: one in the extended-address phase and one in the read turnaround. Each is followed by a retry through the normal command path.

// File: rtl/ulpi_rsp_pkg.sv
// Shared types and constants for the ULPI register responder.
// Assumes byte-wide bus and the fixed two-bit command code in bits [7:6].
package ulpi_rsp_pkg;

    localparam int BYTE_W = 8;
    localparam int CMD_AW = 6;

    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam logic [1:0] OP_READ  = 2'b11;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_ACK,
        S_EXT_WAIT,
        S_EXT_ACK,
        S_WD_WAIT,
        S_WD_ACK,
        S_STP_WAIT,
        S_RD_TURN,
        S_RD_DATA,
        S_RD_END,
        S_ABORT,
        S_AB_END
    } rsp_state_t;

    // Reset value of immediate register idx.
    function automatic logic [BYTE_W-1:0] imm_reset_val(int unsigned idx);
        return 8'hA0 ^ BYTE_W'(idx);
    endfunction

    // Reset value of extended register idx.
    function automatic logic [BYTE_W-1:0] ext_reset_val(int unsigned idx);
        return 8'hFF ^ BYTE_W'(idx);
    endfunction

endpackage

// File: rtl/ulpi_rsp_cmd_dec.sv
// Command byte decoder.
// Classifies a bus byte as a register read, a register write or nothing,
// and flags the escape address that opens the extended register set.
// Purely combinational; the caller decides when the byte is sampled.
module ulpi_rsp_cmd_dec
    import ulpi_rsp_pkg::*;
#(
    parameter logic [CMD_AW-1:0] EXT_CODE = 6'h2F
) (
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_valid,
    output logic              cmd_read,
    output logic              cmd_ext,
    output logic [CMD_AW-1:0] cmd_addr
);

    // Split the byte into opcode and address, then classify.
    always_comb begin
        cmd_addr  = cmd_byte[CMD_AW-1:0];
        cmd_read  = (cmd_byte[7:6] == OP_READ);
        cmd_valid = (cmd_byte[7:6] == OP_READ) || (cmd_byte[7:6] == OP_WRITE);
        cmd_ext   = (cmd_byte[CMD_AW-1:0] == EXT_CODE);
    end

endmodule

// File: rtl/ulpi_rsp_regbank.sv
// One bank of byte registers with per-entry reset values.
// EXT_BANK picks which reset formula seeds the bank.
// Assumes DEPTH is a power of two so every address is in range.
module ulpi_rsp_regbank
    import ulpi_rsp_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter bit EXT_BANK = 1'b0,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mem_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        // Hold one byte: reset value on reset, new byte on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[gi] <= EXT_BANK ? ext_reset_val(gi) : imm_reset_val(gi);
            end else if (wr_en && (wr_addr == AW'(gi))) begin
                mem_q[gi] <= wr_data;
            end
        end
    end

    // Asynchronous read of the addressed byte.
    always_comb rd_data = mem_q[rd_addr];

endmodule

// File: rtl/ulpi_rsp_ctrl.sv
// Bus-side control state machine.
// Accepts commands in idle, paces each byte with a single NXT pulse,
// turns the bus around for reads and waits for STP before committing
// writes. A receive event overrides every state and abandons the access.
// Outputs are decoded from the state register, so they change only
// after a clock edge.
module ulpi_rsp_ctrl
    import ulpi_rsp_pkg::*;
#(
    parameter logic [CMD_AW-1:0] EXT_CODE = 6'h2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] bus_in,
    input  logic              stp,
    input  logic              rx_event,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              nxt,
    output logic              dir,
    output logic              data_oe,
    output logic [BYTE_W-1:0] data_out,
    output logic              wr_en,
    output logic              sel_ext,
    output logic [BYTE_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] wr_byte
);

    rsp_state_t        state_q, state_d;
    logic              is_read_q;
    logic              is_ext_q;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] wdata_q;
    logic [BYTE_W-1:0] dout_q;

    logic              cmd_valid;
    logic              cmd_read;
    logic              cmd_ext;
    logic [CMD_AW-1:0] cmd_addr;

    ulpi_rsp_cmd_dec #(.EXT_CODE(EXT_CODE)) u_dec (
        .cmd_byte (bus_in),
        .cmd_valid(cmd_valid),
        .cmd_read (cmd_read),
        .cmd_ext  (cmd_ext),
        .cmd_addr (cmd_addr)
    );

    // Next-state selection; a receive event wins over every state.
    always_comb begin
        state_d = state_q;
        if (rx_event) begin
            state_d = S_ABORT;
        end else begin
            case (state_q)
                S_IDLE:     if (cmd_valid) state_d = S_CMD_ACK;
                S_CMD_ACK:  state_d = is_ext_q ? S_EXT_WAIT
                                    : (is_read_q ? S_RD_TURN : S_WD_WAIT);
                S_EXT_WAIT: state_d = S_EXT_ACK;
                S_EXT_ACK:  state_d = is_read_q ? S_RD_TURN : S_WD_WAIT;
                S_WD_WAIT:  state_d = S_WD_ACK;
                S_WD_ACK:   state_d = S_STP_WAIT;
                S_STP_WAIT: if (stp) state_d = S_IDLE;
                S_RD_TURN:  state_d = S_RD_DATA;
                S_RD_DATA:  state_d = S_RD_END;
                S_RD_END:   state_d = S_IDLE;
                S_ABORT:    state_d = S_AB_END;
                S_AB_END:   state_d = S_IDLE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Capture command fields, extended address, write data and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_read_q <= 1'b0;
            is_ext_q  <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            dout_q    <= '0;
        end else if (!rx_event) begin
            if (state_q == S_IDLE && cmd_valid) begin
                is_read_q <= cmd_read;
                is_ext_q  <= cmd_ext;
                addr_q    <= BYTE_W'(cmd_addr);
            end
            if (state_q == S_EXT_WAIT) addr_q  <= bus_in;
            if (state_q == S_WD_WAIT)  wdata_q <= bus_in;
            if (state_q == S_RD_TURN)  dout_q  <= rd_byte;
        end
    end

    // Bus outputs decoded from the state register.
    always_comb begin
        nxt      = (state_q == S_CMD_ACK) || (state_q == S_EXT_ACK)
                || (state_q == S_WD_ACK);
        dir      = (state_q == S_RD_TURN) || (state_q == S_RD_DATA)
                || (state_q == S_ABORT);
        data_oe  = (state_q == S_RD_DATA);
        data_out = data_oe ? dout_q : '0;
    end

    // Register-bank side: commit only on the STP edge without an abort.
    always_comb begin
        wr_en    = (state_q == S_STP_WAIT) && stp && !rx_event;
        sel_ext  = is_ext_q;
        acc_addr = addr_q;
        wr_byte  = wdata_q;
    end

endmodule

// File: rtl/ulpi_reg_responder.sv
// Top level of the ULPI PHY-side register responder.
// Joins the control state machine to an immediate and an extended
// register bank. Assumes the link follows the one-byte-per-NXT pacing
// and holds each byte until it has seen NXT for it.
module ulpi_reg_responder
    import ulpi_rsp_pkg::*;
#(
    parameter int                IMM_DEPTH = 64,
    parameter int                EXT_DEPTH = 256,
    parameter logic [CMD_AW-1:0] EXT_CODE  = 6'h2F,
    localparam int               IMM_AW    = $clog2(IMM_DEPTH),
    localparam int               EXT_AW    = $clog2(EXT_DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  ulpi_data_in,
    output logic [7:0]  ulpi_data_out,
    output logic        ulpi_data_oe,
    output logic        ulpi_dir,
    output logic        ulpi_nxt,
    input  logic        ulpi_stp,
    input  logic        rx_event
);

    logic              wr_en;
    logic              sel_ext;
    logic [BYTE_W-1:0] acc_addr;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] imm_rd;
    logic [BYTE_W-1:0] ext_rd;

    ulpi_rsp_ctrl #(.EXT_CODE(EXT_CODE)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_in  (ulpi_data_in),
        .stp     (ulpi_stp),
        .rx_event(rx_event),
        .rd_byte (rd_byte),
        .nxt     (ulpi_nxt),
        .dir     (ulpi_dir),
        .data_oe (ulpi_data_oe),
        .data_out(ulpi_data_out),
        .wr_en   (wr_en),
        .sel_ext (sel_ext),
        .acc_addr(acc_addr),
        .wr_byte (wr_byte)
    );

    ulpi_rsp_regbank #(.DEPTH(IMM_DEPTH), .EXT_BANK(1'b0)) u_imm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && !sel_ext),
        .wr_addr(acc_addr[IMM_AW-1:0]),
        .wr_data(wr_byte),
        .rd_addr(acc_addr[IMM_AW-1:0]),
        .rd_data(imm_rd)
    );

    ulpi_rsp_regbank #(.DEPTH(EXT_DEPTH), .EXT_BANK(1'b1)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && sel_ext),
        .wr_addr(acc_addr[EXT_AW-1:0]),
        .wr_data(wr_byte),
        .rd_addr(acc_addr[EXT_AW-1:0]),
        .rd_data(ext_rd)
    );

    // Pick the bank that the current access addresses.
    always_comb rd_byte = sel_ext ? ext_rd : imm_rd;

endmodule

// File: rtl/ulpi_rsp_checker.sv
// Protocol checker for the register responder, bound to the top level.
// Observes only top-level ports.
module ulpi_rsp_checker (
    input logic clk,
    input logic rst_n,
    input logic ulpi_dir,
    input logic ulpi_nxt,
    input logic ulpi_data_oe,
    input logic rx_event
);

    // R4: the acceptance strobe never coincides with bus ownership.
    a_r4_no_nxt_with_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_dir |-> !ulpi_nxt);

    // R2: each acceptance is a single-cycle pulse.
    a_r2_nxt_single: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_nxt |=> !ulpi_nxt);

    // R3: data is only driven while owning the bus.
    a_r3_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_data_oe |-> ulpi_dir);

    // R3: a turnaround cycle with DIR high precedes any driven byte.
    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_data_oe |-> $past(ulpi_dir));

    // R3: after the returned byte the bus is released, unless a receive event took over.
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ulpi_data_oe) && !$past(rx_event)) |-> !ulpi_dir);

    // R9: a receive event takes the bus on the next cycle with no strobe or data.
    a_r9_rx_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> (ulpi_dir && !ulpi_nxt && !ulpi_data_oe));

endmodule

bind ulpi_reg_responder ulpi_rsp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ulpi_dir    (ulpi_dir),
    .ulpi_nxt    (ulpi_nxt),
    .ulpi_data_oe(ulpi_data_oe),
    .rx_event    (rx_event)
);

// File: tb/tb_ulpi_reg_responder.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
// Inputs are driven and outputs sampled at the falling edge.
module tb_ulpi_reg_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       dir;
    logic       nxt;
    logic       stp = 1'b0;
    logic       rx = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_imm [64];
    logic [7:0] m_ext [256];

    always #2.5 clk = ~clk;

    ulpi_reg_responder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ulpi_data_in (data_in),
        .ulpi_data_out(data_out),
        .ulpi_data_oe (data_oe),
        .ulpi_dir     (dir),
        .ulpi_nxt     (nxt),
        .ulpi_stp     (stp),
        .rx_event     (rx)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Read immediate or extended register and compare with the model.
    task automatic do_read(input bit ext, input logic [7:0] a, input string req);
        logic [7:0] exp = ext ? m_ext[a] : m_imm[a[5:0]];
        data_in = {2'b11, ext ? 6'h2F : a[5:0]};
        tick();
        chk("R2", "read cmd nxt", 32'(nxt), 1);
        tick();
        if (ext) begin
            data_in = a;
            chk("R5", "nxt low before ext addr ack", 32'(nxt), 0);
            tick();
            chk("R5", "ext addr nxt", 32'(nxt), 1);
            tick();
        end
        data_in = 8'h00;
        chk("R3", "turnaround dir", 32'(dir), 1);
        chk("R3", "turnaround oe", 32'(data_oe), 0);
        chk("R4", "nxt during dir", 32'(nxt), 0);
        tick();
        chk("R3", "data cycle oe", 32'(data_oe), 1);
        chk("R3", "data cycle dir", 32'(dir), 1);
        chk(req, "read byte", 32'(data_out), 32'(exp));
        tick();
        chk("R3", "release dir", 32'(dir), 0);
        chk("R3", "release oe", 32'(data_oe), 0);
        tick();
    endtask

    // Full write with STP; updates the model.
    task automatic do_write(input bit ext, input logic [7:0] a,
                            input logic [7:0] d, input string req);
        data_in = {2'b10, ext ? 6'h2F : a[5:0]};
        tick();
        chk("R2", "write cmd nxt", 32'(nxt), 1);
        tick();
        if (ext) begin
            data_in = a;
            chk("R5", "nxt low before ext addr ack", 32'(nxt), 0);
            tick();
            chk("R5", "ext addr nxt", 32'(nxt), 1);
            tick();
        end
        data_in = d;
        chk("R6", "nxt low before data ack", 32'(nxt), 0);
        tick();
        chk("R6", "data nxt", 32'(nxt), 1);
        tick();
        data_in = 8'h00;
        stp = 1'b1;
        tick();
        stp = 1'b0;
        if (ext) m_ext[a] = d;
        else     m_imm[a[5:0]] = d;
        chk(req, "no dir after commit", 32'(dir), 0);
    endtask

    // Hold a receive event for n cycles and release it.
    task automatic rx_pulse(input int n);
        rx = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick();
            chk("R9", "dir during rx", 32'(dir), 1);
            chk("R9", "nxt during rx", 32'(nxt), 0);
            chk("R9", "oe during rx", 32'(data_oe), 0);
        end
        rx = 1'b0;
        tick();
        chk("R9", "dir released", 32'(dir), 0);
        tick();
    endtask

    task automatic t_reset();
        chk("R1", "dir", 32'(dir), 0);
        chk("R1", "nxt", 32'(nxt), 0);
        chk("R1", "oe", 32'(data_oe), 0);
        do_read(1'b0, 8'd0,   "R1");
        do_read(1'b0, 8'd63,  "R1");
        do_read(1'b1, 8'd0,   "R1");
        do_read(1'b1, 8'd255, "R1");
    endtask

    task automatic t_invalid_cmd();
        data_in = 8'h41;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2", "no nxt for non-register byte", 32'(nxt), 0);
            chk("R2", "no dir for non-register byte", 32'(dir), 0);
        end
        data_in = 8'h00;
        tick();
    endtask

    task automatic t_imm_write();
        do_write(1'b0, 8'd5, 8'h3C, "R7");
        do_read(1'b0, 8'd5, "R7");
        do_write(1'b0, 8'd46, 8'hE1, "R7");
        do_read(1'b0, 8'd46, "R7");
        do_read(1'b1, 8'd46, "R10");
    endtask

    task automatic t_stp_gate();
        data_in = 8'h8A;
        tick();
        chk("R2", "write cmd nxt", 32'(nxt), 1);
        tick();
        data_in = 8'h77;
        tick();
        chk("R6", "data nxt", 32'(nxt), 1);
        tick();
        data_in = 8'hC3;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8", "command ignored before stp", 32'(nxt), 0);
            chk("R8", "no dir before stp", 32'(dir), 0);
        end
        data_in = 8'h00;
        stp = 1'b1;
        tick();
        stp = 1'b0;
        m_imm[10] = 8'h77;
        do_read(1'b0, 8'd10, "R8");
    endtask

    task automatic t_ext_write();
        do_write(1'b1, 8'h80, 8'h99, "R10");
        do_read(1'b1, 8'h80, "R10");
        do_read(1'b0, 8'h00, "R10");
        do_write(1'b1, 8'h2F, 8'h12, "R5");
        do_read(1'b1, 8'h2F, "R5");
    endtask

    task automatic t_rx_idle();
        rx_pulse(1);
        rx_pulse(4);
    endtask

    task automatic t_rx_read();
        data_in = 8'hC7;
        tick();
        chk("R2", "read cmd nxt", 32'(nxt), 1);
        tick();
        data_in = 8'h00;
        chk("R3", "turnaround dir", 32'(dir), 1);
        rx_pulse(3);
        do_read(1'b0, 8'd7, "R9");
    endtask

    task automatic t_rx_stp();
        data_in = 8'h94;
        tick();
        tick();
        data_in = 8'h5E;
        tick();
        chk("R6", "data nxt", 32'(nxt), 1);
        tick();
        data_in = 8'h00;
        stp = 1'b1;
        rx = 1'b1;
        tick();
        stp = 1'b0;
        chk("R9", "dir on rx with stp", 32'(dir), 1);
        rx_pulse(1);
        do_read(1'b0, 8'd20, "R9");
    endtask

    task automatic t_rx_ext_addr();
        data_in = 8'hAF;
        tick();
        chk("R5", "ext write cmd nxt", 32'(nxt), 1);
        tick();
        data_in = 8'h80;
        rx = 1'b1;
        tick();
        data_in = 8'h00;
        chk("R9", "nxt suppressed in ext addr", 32'(nxt), 0);
        rx_pulse(1);
        do_read(1'b1, 8'h80, "R9");
    endtask

    initial begin
        for (int i = 0; i < 64; i++)  m_imm[i] = 8'hA0 ^ 8'(i);
        for (int i = 0; i < 256; i++) m_ext[i] = 8'hFF ^ 8'(i);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_invalid_cmd();
        t_imm_write();
        t_stp_gate();
        t_ext_write();
        t_rx_idle();
        t_rx_read();
        t_rx_stp();
        t_rx_ext_addr();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule